// File: doc/BRIEF.md
# Watchdog Timer with Power-Mode Handling

This block watches software health. A main counter advances on the selected clock, either the bus clock or a low-power clock. Unless software performs a two-word refresh in time, the counter reaches a programmed limit and the block asks for a system reset. It can also raise an interrupt first and delay the reset by a fixed number of ticks. Configuration (the control word and the timeout limit) can only be written inside a window that opens after a reset or after a two-word unlock. If an unlock is not followed by configuration in time, the block forces a reset.

Debug, wait and stop mode inputs change the behaviour. The counter freezes in any mode whose enable bit is clear. Debug entered during the post-reset window parks the counter at zero and restarts the window on exit. When the bus clock is gated in stop mode, a backup path needs two full timeouts before it resets, and it stays silent: it raises no interrupt and leaves the reset count unchanged. The reset request is a one-cycle pulse. On that pulse the block re-initialises everything except its reset count, which only the power-on reset clears.

Top module: `wdg_core`

## Requirements
- R1: While `rst_n` is low, the reads return these values: control (address 0) `0x0001`, limit (address 1) `TO_DEF`, timer (address 2) 0, reset count (address 3) 0. Both `irq` and `rst_req` are low.
- R2: Interrupt disabled (control bit 1 clear): `rst_req` goes high for one cycle exactly limit ticks of the selected clock after the counter last restarted at zero. The count goes up by one. The next cycle restores control, limit and timer to their R1 values.
- R3: A refresh is key `0xA5C3` then key `0x3C5A`, both written to address 2, with the second arriving at most `REF_GAP` bus ticks after the first. It clears the timer to zero. If the gap runs out, the pending refresh is dropped without a reset.
- R4: An unlock is key `0xD928` followed directly by key `0x1C8F`, and it opens the configuration window. Any of the following causes `rst_req` on the write's own clock edge and adds one to the count: a wrong key, a second key with no matching first, or a wrong follow-up to a first key.
- R5: Writes to control (address 0, bits 5:0) and to the limit (address 1) take effect only while the window is open. At other times they are ignored. A control write closes the window.
- R6: An unlock window with no control write for `WIN_CYC` bus ticks ends in a reset, whether or not debug mode is active. If the post-reset window expires, it closes silently.
- R7: Interrupt enabled (control bit 1 set): a timeout or an expired unlock window raises `irq` instead of `rst_req`. `irq` stays high, and `rst_req` follows `IRQ_DLY` selected-clock ticks later.
- R8: In debug mode with control bit 2 clear, the timer holds its value and resumes from it when debug ends. Key writes are still accepted, so a refresh clears the timer.
- R9: Debug entered while the post-reset window is open holds the timer at zero and keeps the window from expiring. On exit, both the timer and a full window start over.
- R10: Wait mode freezes the timer unless control bit 3 is set. Stop mode freezes it unless control bit 4 is set. When enabled, wait mode times out with the normal interrupt and reset behaviour, including the count increment.
- R11: In stop mode with the bus clock gated, the timer runs only when control bit 4 is set and bit 5 selects the low-power clock. The reset comes after twice the limit in ticks. `irq` stays low and the count is unchanged. With the bus clock selected, the timer stays frozen.
- R12: The reset count is `RC_W` bits wide and saturates at all ones. Writing `0xFFFF` to address 3 clears it. Any other value written there is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_tick | input | 1 | Bus clock enable |
| lp_tick | input | 1 | Low-power clock enable |
| bus_gated | input | 1 | Bus clock is gated off (stop mode) |
| dbg_mode | input | 1 | System is in debug mode |
| wait_mode | input | 1 | System is in wait mode |
| stop_mode | input | 1 | System is in stop mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 limit, 2 key, 3 reset count |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 limit, 2 timer, 3 reset count |
| rd_data | output | 16 | Read data |
| irq | output | 1 | Pre-reset interrupt |
| rst_req | output | 1 | One-cycle reset request |
| rst_count | output | RC_W | Watchdog reset count |

## Verification
The timeout latency is swept over limits 1 to 8 in normal mode and 2 to 5 in the gated stop path. Each run measures the exact cycle of `rst_req`, which distinguishes an off-by-one compare from a doubled or undoubled backup timeout. The key inputs are tried in every order: correct pairs, wrong follow-ups, a lone second key and a late second key. This separates a refresh from an unlock and a sequence error from a dropped sequence. The mode inputs are applied with their enable bits both clear and set, and the timer is read back each time to tell a frozen counter from a running one. The debug tests use entry inside and outside the post-reset window to separate a zero-hold from a plain freeze.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam logic [15:0] KEY_REF_A = 16'hA5C3;
  localparam logic [15:0] KEY_REF_B = 16'h3C5A;
  localparam logic [15:0] KEY_UNL_A = 16'hD928;
  localparam logic [15:0] KEY_UNL_B = 16'h1C8F;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_LIM  = 2'd1;
  localparam logic [1:0] ADR_KEY  = 2'd2;
  localparam logic [1:0] ADR_RCNT = 2'd3;

  typedef struct packed {
    logic clk_lp;
    logic stop_en;
    logic wait_en;
    logic dbg_en;
    logic irq_en;
    logic en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = 6'b000001;

  // Timeout compare: the tick that would bring the count to the limit.
  function automatic logic tmo_hit(input logic [15:0] c, input logic [15:0] lim);
    return ({1'b0, c} + 17'd1) >= {1'b0, lim};
  endfunction

endpackage

// File: rtl/wdg_keyseq.sv
module wdg_keyseq
  import wdg_pkg::*;
#(
  parameter int REF_GAP = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        key_wr,
  input  logic [15:0] key_val,
  input  logic        bus_run,
  output logic        refresh,
  output logic        unlock,
  output logic        key_err
);
  localparam int GW = $clog2(REF_GAP + 1);

  typedef enum logic [1:0] {KS_IDLE, KS_REF, KS_UNL} kstage_t;
  kstage_t stage;
  logic [GW-1:0] gap;
  logic gap_out, first_ok;

  assign refresh  = key_wr && stage == KS_REF && key_val == KEY_REF_B;
  assign unlock   = key_wr && stage == KS_UNL && key_val == KEY_UNL_B;
  assign first_ok = stage == KS_IDLE && (key_val == KEY_REF_A || key_val == KEY_UNL_A);
  assign key_err  = key_wr && !refresh && !unlock && !first_ok;
  assign gap_out  = stage == KS_REF && bus_run && gap == GW'(REF_GAP - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= KS_IDLE;
      gap   <= '0;
    end else if (clr) begin
      stage <= KS_IDLE;
      gap   <= '0;
    end else if (key_wr) begin
      gap <= '0;
      if (first_ok && key_val == KEY_REF_A)      stage <= KS_REF;
      else if (first_ok && key_val == KEY_UNL_A) stage <= KS_UNL;
      else                                       stage <= KS_IDLE;
    end else if (gap_out) begin
      stage <= KS_IDLE;
    end else if (stage == KS_REF && bus_run) begin
      gap <= gap + 1'b1;
    end
  end

  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stage == KS_REF |-> gap < GW'(REF_GAP)); // R3

endmodule

// File: rtl/wdg_window.sv
module wdg_window #(
  parameter int WIN_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bus_run,
  input  logic unlock,
  input  logic cfg_done,
  input  logic dbg_mode,
  output logic open_o,
  output logic hold_o,
  output logic win_err
);
  localparam int WW = $clog2(WIN_CYC + 1);

  logic          boot;
  logic [WW-1:0] wcnt;
  logic          expire;

  assign hold_o  = open_o && boot && dbg_mode;
  assign expire  = open_o && bus_run && !hold_o && wcnt == WW'(WIN_CYC - 1);
  assign win_err = expire && !boot && !cfg_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o <= 1'b1;
      boot   <= 1'b1;
      wcnt   <= '0;
    end else if (clr) begin
      open_o <= 1'b1;
      boot   <= 1'b1;
      wcnt   <= '0;
    end else if (unlock) begin
      open_o <= 1'b1;
      boot   <= 1'b0;
      wcnt   <= '0;
    end else if (cfg_done) begin
      open_o <= 1'b0;
    end else if (hold_o) begin
      wcnt <= '0;
    end else if (expire) begin
      open_o <= 1'b0;
    end else if (open_o && bus_run) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    open_o |-> wcnt < WW'(WIN_CYC)); // R6

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        hold0,
  input  logic        refresh,
  input  logic        run,
  input  logic        backup,
  input  logic [15:0] limit,
  output logic [15:0] cnt,
  output logic        to_evt,
  output logic        bk_evt
);
  logic half, hit, live;

  assign hit    = tmo_hit(cnt, limit);
  assign live   = run && !clr && !hold0 && !refresh;
  assign to_evt = live && hit && !backup;
  assign bk_evt = live && hit && backup && half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      half <= 1'b0;
    end else if (clr || hold0 || refresh) begin
      cnt  <= '0;
      half <= 1'b0;
    end else begin
      if (!backup) half <= 1'b0;
      if (run) begin
        if (!hit) begin
          cnt <= cnt + 16'd1;
        end else if (backup && !half) begin
          half <= 1'b1;
          cnt  <= '0;
        end
      end
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    live && !hit |=> cnt == $past(cnt) + 16'd1); // R2

endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
#(
  parameter int          WIN_CYC = 256,
  parameter int          IRQ_DLY = 128,
  parameter int          REF_GAP = 20,
  parameter int          RC_W    = 16,
  parameter logic [15:0] TO_DEF  = 16'h0400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_tick,
  input  logic            lp_tick,
  input  logic            bus_gated,
  input  logic            dbg_mode,
  input  logic            wait_mode,
  input  logic            stop_mode,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [15:0]     wr_data,
  input  logic [1:0]      rd_addr,
  output logic [15:0]     rd_data,
  output logic            irq,
  output logic            rst_req,
  output logic [RC_W-1:0] rst_count
);
  localparam int DW = $clog2(IRQ_DLY + 1);
  localparam logic [RC_W-1:0] RC_MAX = '1;

  ctrl_t       ctrl;
  logic [15:0] limit;
  logic [DW-1:0] dly;
  logic        irq_pend;

  logic bus_run, sel_tick, wr_ok, key_wr, cfg_wr, cfg_done, rcnt_clr;
  logic refresh, unlock, key_err;
  logic win_open, hold0, win_err;
  logic run, backup, to_evt, bk_evt;
  logic [15:0] tmr_cnt;
  logic irq_start, dly_done, fire_cnt, fire;

  assign bus_run  = bus_tick && !bus_gated;
  assign sel_tick = ctrl.clk_lp ? lp_tick : bus_run;
  assign wr_ok    = wr_en && !bus_gated;
  assign key_wr   = wr_ok && wr_addr == ADR_KEY;
  assign cfg_wr   = wr_ok && win_open && !rst_req;
  assign cfg_done = cfg_wr && wr_addr == ADR_CTRL;
  assign rcnt_clr = wr_ok && wr_addr == ADR_RCNT && wr_data == 16'hFFFF;

  assign run = sel_tick && ctrl.en
            && !(dbg_mode  && !ctrl.dbg_en)
            && !(wait_mode && !ctrl.wait_en)
            && !(stop_mode && !ctrl.stop_en);
  assign backup = stop_mode && bus_gated;

  wdg_keyseq #(.REF_GAP(REF_GAP)) u_key (
    .clk(clk), .rst_n(rst_n), .clr(rst_req), .key_wr(key_wr), .key_val(wr_data),
    .bus_run(bus_run), .refresh(refresh), .unlock(unlock), .key_err(key_err)
  );

  wdg_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(rst_req), .bus_run(bus_run), .unlock(unlock),
    .cfg_done(cfg_done), .dbg_mode(dbg_mode), .open_o(win_open), .hold_o(hold0),
    .win_err(win_err)
  );

  wdg_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(rst_req), .hold0(hold0), .refresh(refresh),
    .run(run), .backup(backup), .limit(limit), .cnt(tmr_cnt), .to_evt(to_evt),
    .bk_evt(bk_evt)
  );

  assign irq_start = (to_evt || win_err) && ctrl.irq_en && !irq_pend && !rst_req;
  assign dly_done  = irq_pend && sel_tick && dly == DW'(IRQ_DLY - 1);
  assign fire_cnt  = key_err || dly_done || ((to_evt || win_err) && !ctrl.irq_en);
  assign fire      = (fire_cnt || bk_evt) && !rst_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= CTRL_RST;
      limit <= TO_DEF;
    end else if (rst_req) begin
      ctrl  <= CTRL_RST;
      limit <= TO_DEF;
    end else if (cfg_wr) begin
      if (wr_addr == ADR_CTRL) ctrl  <= ctrl_t'(wr_data[5:0]);
      if (wr_addr == ADR_LIM)  limit <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pend <= 1'b0;
      dly      <= '0;
    end else if (rst_req) begin
      irq_pend <= 1'b0;
      dly      <= '0;
    end else if (irq_start) begin
      irq_pend <= 1'b1;
      dly      <= '0;
    end else if (irq_pend && sel_tick && !dly_done) begin
      dly <= dly + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req   <= 1'b0;
      rst_count <= '0;
    end else begin
      rst_req <= fire;
      if (rcnt_clr)                                            rst_count <= '0;
      else if (fire_cnt && !rst_req && rst_count != RC_MAX)    rst_count <= rst_count + 1'b1;
    end
  end

  assign irq = irq_pend;

  always_comb begin
    case (rd_addr)
      ADR_CTRL: rd_data = {10'd0, ctrl};
      ADR_LIM:  rd_data = limit;
      ADR_KEY:  rd_data = tmr_cnt;
      default:  rd_data = 16'(rst_count);
    endcase
  end

  AST_RST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R2
  AST_KEY_ERR_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    key_err && !rst_req |=> rst_req); // R4
  AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode && !ctrl.dbg_en && !hold0 && !refresh && !rst_req |=> $stable(tmr_cnt)); // R8
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hold0 |=> tmr_cnt == 16'd0); // R9
  AST_BK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bk_evt && !irq_pend && !rst_req |=> rst_req && !irq); // R11
  AST_BK_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    bk_evt && !fire_cnt && !rcnt_clr |=> $stable(rst_count)); // R11
  AST_RCNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_count == RC_MAX && !rcnt_clr |=> rst_count == RC_MAX); // R12

endmodule

// File: tb/sim_wdg_core.sv
`timescale 1ns/1ps
module sim_wdg_core;
  localparam int WIN = 16;
  localparam int DLY = 8;
  localparam int RCW = 4;
  localparam logic [15:0] TDEF = 16'd1000;
  localparam logic [15:0] RA = 16'hA5C3, RB = 16'h3C5A, UA = 16'hD928, UB = 16'h1C8F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_tick = 1'b1, lp_tick = 1'b1, bus_gated = 1'b0;
  logic dbg_mode = 1'b0, wait_mode = 1'b0, stop_mode = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] rd_data;
  logic irq, rst_req;
  logic [RCW-1:0] rst_count;

  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  wdg_core #(.WIN_CYC(WIN), .IRQ_DLY(DLY), .REF_GAP(20), .RC_W(RCW), .TO_DEF(TDEF)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .lp_tick(lp_tick), .bus_gated(bus_gated),
    .dbg_mode(dbg_mode), .wait_mode(wait_mode), .stop_mode(stop_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .rst_req(rst_req), .rst_count(rst_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic hard_reset();
    rst_n = 1'b0; dbg_mode = 1'b0; wait_mode = 1'b0; stop_mode = 1'b0;
    bus_gated = 1'b0; bus_tick = 1'b1; lp_tick = 1'b1; wr_en = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  // Configure under a post-reset debug hold, refresh, leave debug asserted.
  task automatic cfg(input logic [5:0] c, input logic [15:0] t);
    hard_reset();
    dbg_mode = 1'b1;
    tick(1);
    bus_wr(2'd1, t);
    bus_wr(2'd0, {10'd0, c});
    bus_wr(2'd2, RA);
    bus_wr(2'd2, RB);
  endtask

  task automatic wait_rst(input int lim, output int n);
    n = 0;
    while (!rst_req && n < lim) begin tick(1); n++; end
  endtask

  task automatic wait_irq(input int lim, output int n);
    n = 0;
    while (!irq && n < lim) begin tick(1); n++; end
  endtask

  initial begin
    #(8 * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int v, v2, n;
    logic seen;
    // R1 reset values
    tick(1);
    bus_rd(2'd0, v); chk("R1 ctrl", v, 1);
    bus_rd(2'd1, v); chk("R1 limit", v, int'(TDEF));
    bus_rd(2'd2, v); chk("R1 timer", v, 0);
    bus_rd(2'd3, v); chk("R1 count", v, 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rst_req", int'(rst_req), 0);

    // R2 timeout latency sweep
    for (int t = 1; t <= 8; t++) begin
      cfg(6'h01, 16'(t));
      dbg_mode = 1'b0;
      wait_rst(100, n);
      chk("R2 latency", n, t);
      bus_rd(2'd3, v); chk("R2 count", v, 1);
      tick(1);
      chk("R2 one-cycle pulse", int'(rst_req), 0);
      bus_rd(2'd0, v); chk("R2 ctrl restored", v, 1);
      bus_rd(2'd1, v); chk("R2 limit restored", v, int'(TDEF));
      bus_rd(2'd2, v); chk("R2 timer restored", v, 0);
    end

    // R7 interrupt then delayed reset
    cfg(6'h03, 16'd5);
    dbg_mode = 1'b0;
    wait_irq(100, n);
    chk("R7 irq latency", n, 5);
    chk("R7 no early reset", int'(rst_req), 0);
    wait_rst(100, n);
    chk("R7 reset delay", n, DLY);
    chk("R7 irq held", int'(irq), 1);
    bus_rd(2'd3, v); chk("R7 count", v, 1);

    // R3 refresh and gap expiry
    cfg(6'h01, 16'd200);
    dbg_mode = 1'b0;
    tick(10);
    bus_wr(2'd2, RA); bus_wr(2'd2, RB);
    bus_rd(2'd2, v); chk("R3 refresh clears", v, 0);
    tick(5);
    bus_rd(2'd2, v); chk("R3 counting after refresh", v, 5);
    bus_wr(2'd2, RA);
    seen = 1'b0;
    for (int i = 0; i < 25; i++) begin tick(1); if (rst_req) seen = 1'b1; end
    chk("R3 gap expiry silent", int'(seen), 0);
    bus_wr(2'd2, RB);
    chk("R4 lone second key resets", int'(rst_req), 1);
    bus_rd(2'd3, v); chk("R4 count after lone key", v, 1);

    // R4 unlock, R5 window gating
    cfg(6'h01, 16'd1000);
    dbg_mode = 1'b0;
    bus_wr(2'd1, 16'd55);
    bus_rd(2'd1, v); chk("R5 limit write closed", v, 1000);
    bus_wr(2'd2, UA); bus_wr(2'd2, UB);
    bus_wr(2'd1, 16'd77);
    bus_rd(2'd1, v); chk("R4 unlock opens window", v, 77);
    bus_wr(2'd0, 16'h0001);
    bus_wr(2'd1, 16'd88);
    bus_rd(2'd1, v); chk("R5 closed after ctrl", v, 77);
    bus_wr(2'd0, 16'h0003);
    bus_rd(2'd0, v); chk("R5 ctrl write closed", v, 1);
    bus_wr(2'd2, UA); bus_wr(2'd2, 16'h1234);
    chk("R4 wrong second key", int'(rst_req), 1);
    tick(1);
    bus_wr(2'd2, 16'hBEEF);
    chk("R4 unknown first key", int'(rst_req), 1);
    tick(1);
    bus_wr(2'd2, RA); bus_wr(2'd2, UB);
    chk("R4 mismatched pair", int'(rst_req), 1);
    bus_rd(2'd3, v); chk("R4 count", v, 3);

    // R6 unlock window expiry, with and without debug
    for (int d = 0; d < 2; d++) begin
      cfg(6'h01, 16'd1000);
      dbg_mode = d[0];
      bus_wr(2'd2, UA); bus_wr(2'd2, UB);
      wait_rst(100, n);
      chk("R6 unlock window expiry", n, WIN);
      bus_rd(2'd3, v); chk("R6 count", v, 1);
    end
    cfg(6'h03, 16'd1000);
    dbg_mode = 1'b0;
    bus_wr(2'd2, UA); bus_wr(2'd2, UB);
    wait_irq(100, n);
    chk("R7 window expiry irq", n, WIN);
    wait_rst(100, n);
    chk("R7 window expiry delay", n, DLY);
    hard_reset();
    seen = 1'b0;
    for (int i = 0; i < WIN + 4; i++) begin tick(1); if (rst_req) seen = 1'b1; end
    chk("R6 boot window silent", int'(seen), 0);
    bus_wr(2'd0, 16'h0003);
    bus_rd(2'd0, v); chk("R6 boot window closed", v, 1);

    // R8 debug freeze
    cfg(6'h01, 16'd300);
    dbg_mode = 1'b0;
    tick(10);
    dbg_mode = 1'b1;
    bus_rd(2'd2, v); chk("R8 value at freeze", v, 10);
    tick(20);
    bus_rd(2'd2, v); chk("R8 frozen", v, 10);
    bus_wr(2'd2, RA); bus_wr(2'd2, RB);
    bus_rd(2'd2, v); chk("R8 refresh in debug", v, 0);
    dbg_mode = 1'b0;
    tick(4);
    bus_rd(2'd2, v); chk("R8 resume", v, 4);
    cfg(6'h05, 16'd300);
    tick(6);
    bus_rd(2'd2, v); chk("R8 runs with debug enable", v, 6);

    // R9 debug inside post-reset window
    hard_reset();
    dbg_mode = 1'b1;
    tick(WIN + 10);
    bus_rd(2'd2, v); chk("R9 held at zero", v, 0);
    chk("R9 no reset", int'(rst_req), 0);
    dbg_mode = 1'b0;
    tick(WIN - 3);
    bus_rd(2'd2, v); chk("R9 restart", v, WIN - 3);
    bus_wr(2'd0, 16'h0003);
    bus_rd(2'd0, v); chk("R9 fresh window", v, 3);

    // R10 wait and stop enables
    cfg(6'h01, 16'd300);
    dbg_mode = 1'b0; wait_mode = 1'b1;
    tick(10);
    bus_rd(2'd2, v); chk("R10 wait freezes", v, 0);
    cfg(6'h09, 16'd300);
    dbg_mode = 1'b0; wait_mode = 1'b1;
    tick(10);
    bus_rd(2'd2, v); chk("R10 wait runs", v, 10);
    cfg(6'h0B, 16'd6);
    dbg_mode = 1'b0; wait_mode = 1'b1;
    wait_irq(100, n); chk("R10 wait irq", n, 6);
    wait_rst(100, n); chk("R10 wait reset", n, DLY);
    bus_rd(2'd3, v); chk("R10 wait count", v, 1);
    cfg(6'h01, 16'd300);
    dbg_mode = 1'b0; stop_mode = 1'b1;
    tick(10);
    bus_rd(2'd2, v); chk("R10 stop freezes", v, 0);
    cfg(6'h11, 16'd300);
    dbg_mode = 1'b0; stop_mode = 1'b1;
    tick(10);
    bus_rd(2'd2, v); chk("R10 stop runs", v, 10);

    // R11 gated stop backup path
    for (int t = 2; t <= 5; t++) begin
      cfg(6'h33, 16'(t));
      dbg_mode = 1'b0; stop_mode = 1'b1; bus_gated = 1'b1;
      n = 0; seen = 1'b0;
      while (!rst_req && n < 100) begin tick(1); n++; if (irq) seen = 1'b1; end
      chk("R11 double timeout", n, 2 * t);
      chk("R11 no irq", int'(seen), 0);
      bus_rd(2'd3, v); chk("R11 count unchanged", v, 0);
    end
    cfg(6'h11, 16'd6);
    dbg_mode = 1'b0; stop_mode = 1'b1; bus_gated = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 30; i++) begin tick(1); if (rst_req) seen = 1'b1; end
    chk("R11 bus clock frozen", int'(seen), 0);
    bus_rd(2'd2, v); chk("R11 timer frozen", v, 0);

    // R12 count saturation and clear
    hard_reset();
    for (int i = 0; i < 17; i++) begin bus_wr(2'd2, 16'h0001); tick(1); end
    bus_rd(2'd3, v); chk("R12 saturates", v, 15);
    bus_wr(2'd3, 16'h1234);
    bus_rd(2'd3, v2); chk("R12 other value ignored", v2, 15);
    bus_wr(2'd3, 16'hFFFF);
    bus_rd(2'd3, v); chk("R12 cleared", v, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule